// File: doc/BRIEF.md
# Capture/Compare 16-bit Timer

A 16-bit up-counter that advances once per prescaled system-clock tick, with two operating modes. In compare mode the counter runs freely through the whole 16-bit range. Each time it passes the programmed compare value it flips the timer output and requests an interrupt, and it keeps counting without being cleared. In capture mode the counter returns to 0001h after it reaches the reload value. An edge of the selected polarity on the synchronized timer input copies the running count into a pair of capture registers, and the counter does not stop.

Software reaches the block through a byte-wide register port. Control bits set the mode, the prescale exponent, the idle output level, the capture polarity and which events raise the interrupt. Software clears the capture pair before it enables capture mode. A zero in that pair after an interrupt then tells software that the interrupt came from a reload and not from a capture. The elapsed time to a capture is (captured − start) × 2^N / f_clk.

Top module: `cc_timer16`

## Requirements
- R1: After reset every register reads 00h, `tmr_out` is 0 and `irq` is 0.
- R2: Register map by `addr`: 0 = control A, 1 = control B, 2/3 = count high/low, 4/5 = reload/compare high/low, 6/7 = capture high/low. Control A bits: [7] run, [6] mode (1 = capture, 0 = compare), [5] idle output level, [4] capture polarity (1 = rising, 0 = falling), [3] reads 0, [2:0] prescale exponent N. Control B bits [1:0] select the interrupt sources, and its upper bits read 0. Writes occur on the rising clock edge while `wr_en` is high, and `rdata` reflects `addr` combinationally.
- R3: While the run bit is set, the count advances once every 2^N clock cycles. The first advance occurs 2^N cycles after the edge that sets the run bit. Clearing the run bit resets the prescaler.
- R4: In compare mode, an advance that starts from a count equal to the compare value raises `irq` for one cycle after that edge, and the counter moves on to the compare value + 1.
- R5: The count wraps from FFFFh to 0000h and keeps counting.
- R6: While the run bit is clear, `tmr_out` takes the idle level. In compare mode each compare match inverts `tmr_out` on the same edge.
- R7: In capture mode, `tmr_in` passes through a two-stage synchronizer. An edge of the selected polarity stores the count into the capture pair on the third clock edge after the input changes, and `irq` rises on that same edge. The counter keeps running.
- R8: An input edge of the opposite polarity leaves the capture pair unchanged and raises no interrupt.
- R9: In capture mode, an advance from a count equal to the reload value loads 0001h and raises a reload interrupt. The capture pair is left unchanged.
- R10: Interrupt select value 00 or 11 enables both event classes, 01 enables only captures, and 10 enables only reload/compare events. A masked event still updates the counter, the output and the capture pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tmr_in | input | 1 | Asynchronous timer input for capture |
| tmr_out | output | 1 | Timer output level |
| irq | output | 1 | Interrupt request, one-cycle pulse per event |

## Verification
The run bit takes effect on the write edge. With exponent N the k-th advance therefore lands on edge k·2^N after it, so the bench predicts the count at edge j as start + ⌊j/2^N⌋ and checks `irq` and `tmr_out` in every cycle of a compare run. A matching advance shows on `irq` and `tmr_out` one edge after it occurs. A capture appears three edges after the input changes and holds the count from the edge before. The bench drives inputs and samples outputs at falling edges and counts edges from the enabling write to schedule each check, and it derives each expected value arithmetically.

// File: rtl/cc_timer16_pkg.sv
package cc_timer16_pkg;

  typedef enum logic [2:0] {
    A_CTLA  = 3'd0,
    A_CTLB  = 3'd1,
    A_CNT_H = 3'd2,
    A_CNT_L = 3'd3,
    A_CMP_H = 3'd4,
    A_CMP_L = 3'd5,
    A_CAP_H = 3'd6,
    A_CAP_L = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    IRQ_ALL    = 2'b00,
    IRQ_CAP    = 2'b01,
    IRQ_RELOAD = 2'b10,
    IRQ_ALL2   = 2'b11
  } irq_sel_e;

  typedef struct packed {
    logic       run;
    logic       cap_mode;
    logic       idle_lvl;
    logic       rise_pol;
    logic       rsvd;
    logic [2:0] exp_n;
  } ctla_t;

endpackage

// File: rtl/cc_prescaler.sv
module cc_prescaler #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] exp_n,
  output logic          tick
);
  localparam int PCW = (1 << PW) - 1;

  logic [PCW-1:0] pcnt_q, pcnt_d, mask;

  always_comb begin
    for (int i = 0; i < PCW; i++) mask[i] = (i < int'(exp_n));
  end

  assign tick = run && ((pcnt_q & mask) == mask);

  always_comb begin
    pcnt_d = pcnt_q;
    if (!run) pcnt_d = '0;
    else      pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  p_presc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt_q == '0));

endmodule

// File: rtl/cc_edge_sync.sv
module cc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/cc_count_core.sv
module cc_count_core #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            cap_mode,
  input  logic [2*DW-1:0] limit,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] count,
  output logic            match
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] cnt_q, cnt_d;

  assign match = tick && (cnt_q == limit);
  assign count = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_hi || wr_lo) begin
      if (wr_hi) cnt_d[CW-1:DW] = wdata;
      if (wr_lo) cnt_d[DW-1:0]  = wdata;
    end else if (tick) begin
      if (match && cap_mode) cnt_d = CW'(1);
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_hi && !wr_lo) |=> $stable(cnt_q));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_hi && !wr_lo && (&cnt_q) && !(cap_mode && limit == cnt_q))
      |=> (cnt_q == '0));

  p_cmp_continue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !cap_mode && !wr_hi && !wr_lo) |=> (cnt_q == $past(limit) + 1'b1));

  p_cap_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cap_mode && cnt_q == limit && !wr_hi && !wr_lo) |=> (cnt_q == CW'(1)));

endmodule

// File: rtl/cc_timer16.sv
module cc_timer16
  import cc_timer16_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PW    = 3,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          tmr_in,
  output logic          tmr_out,
  output logic          irq
);
  localparam int CW = 2 * DW;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // register state
  ctla_t          ctla_q, ctla_d;
  irq_sel_e       isel_q, isel_d;
  logic [CW-1:0]  cmp_q, cmp_d;
  logic [CW-1:0]  cap_q, cap_d;
  logic           out_q, out_d;
  logic           irq_q, irq_d;

  logic [CW-1:0]  count;
  logic           tick, match, rise, fall;
  logic           edge_sel, cap_evt, rld_evt;
  logic           wr_cap_h, wr_cap_l;

  cc_prescaler #(.PW(PW)) u_presc (
    .clk   (clk),
    .rst_n (rst_ni),
    .run   (ctla_q.run),
    .exp_n (ctla_q.exp_n[PW-1:0]),
    .tick  (tick)
  );

  cc_edge_sync #(.STAGES(SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_ni),
    .din   (tmr_in),
    .rise  (rise),
    .fall  (fall)
  );

  cc_count_core #(.DW(DW)) u_core (
    .clk      (clk),
    .rst_n    (rst_ni),
    .tick     (tick),
    .cap_mode (ctla_q.cap_mode),
    .limit    (cmp_q),
    .wr_hi    (wr_en && addr == A_CNT_H),
    .wr_lo    (wr_en && addr == A_CNT_L),
    .wdata    (wdata),
    .count    (count),
    .match    (match)
  );

  assign edge_sel = ctla_q.rise_pol ? rise : fall;
  assign cap_evt  = ctla_q.run && ctla_q.cap_mode && edge_sel;
  assign rld_evt  = match;
  assign wr_cap_h = wr_en && addr == A_CAP_H;
  assign wr_cap_l = wr_en && addr == A_CAP_L;

  always_comb begin
    ctla_d = ctla_q;
    isel_d = isel_q;
    cmp_d  = cmp_q;
    cap_d  = cap_q;
    if (wr_en && addr == A_CTLA) begin
      ctla_d      = ctla_t'(wdata[7:0]);
      ctla_d.rsvd = 1'b0;
    end
    if (wr_en && addr == A_CTLB)  isel_d = irq_sel_e'(wdata[1:0]);
    if (wr_en && addr == A_CMP_H) cmp_d[CW-1:DW] = wdata;
    if (wr_en && addr == A_CMP_L) cmp_d[DW-1:0]  = wdata;
    if (wr_cap_h || wr_cap_l) begin
      if (wr_cap_h) cap_d[CW-1:DW] = wdata;
      if (wr_cap_l) cap_d[DW-1:0]  = wdata;
    end else if (cap_evt) begin
      cap_d = count;
    end
  end

  always_comb begin
    out_d = out_q;
    if (!ctla_q.run)                      out_d = ctla_q.idle_lvl;
    else if (!ctla_q.cap_mode && rld_evt) out_d = ~out_q;
  end

  always_comb begin
    irq_d = (cap_evt && isel_q != IRQ_RELOAD) ||
            (rld_evt && isel_q != IRQ_CAP);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctla_q <= '0;
      isel_q <= IRQ_ALL;
      cmp_q  <= '0;
      cap_q  <= '0;
      out_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctla_q <= ctla_d;
      isel_q <= isel_d;
      cmp_q  <= cmp_d;
      cap_q  <= cap_d;
      out_q  <= out_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    case (reg_addr_e'(addr))
      A_CTLA:  rdata = ctla_q;
      A_CTLB:  rdata = {{(DW-2){1'b0}}, isel_q};
      A_CNT_H: rdata = count[CW-1:DW];
      A_CNT_L: rdata = count[DW-1:0];
      A_CMP_H: rdata = cmp_q[CW-1:DW];
      A_CMP_L: rdata = cmp_q[DW-1:0];
      A_CAP_H: rdata = cap_q[CW-1:DW];
      default: rdata = cap_q[DW-1:0];
    endcase
  end

  assign tmr_out = out_q;
  assign irq     = irq_q;

  p_out_toggle_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctla_q.run && !ctla_q.cap_mode && match) |=> (out_q != $past(out_q)));

  p_out_idle_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !ctla_q.run |=> (out_q == $past(ctla_q.idle_lvl)));

  p_cap_load_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cap_evt && !wr_cap_h && !wr_cap_l) |=> (cap_q == $past(count)));

  p_cap_still_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rise && !fall && !wr_cap_h && !wr_cap_l) |=> $stable(cap_q));

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_q |-> $past((cap_evt && isel_q != IRQ_RELOAD) || (match && isel_q != IRQ_CAP)));

endmodule

// File: tb/cc_timer16_bench.sv
`timescale 1ns/1ps
module cc_timer16_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       tmr_in = 1'b0;
  logic       tmr_out, irq;

  int n_chk  = 0;
  int n_fail = 0;
  int j;

  always #4 clk = ~clk;

  cc_timer16 u_cc_timer16 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .tmr_in(tmr_in), .tmr_out(tmr_out), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd8(input logic [2:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic rd16(input logic [2:0] ahi, output logic [15:0] v);
    logic [7:0] h, l;
    rd8(ahi, h);
    rd8(ahi + 3'd1, l);
    v = {h, l};
  endtask

  task automatic wr16(input logic [2:0] ahi, input logic [15:0] v);
    wr(ahi, v[15:8]);
    wr(ahi + 3'd1, v[7:0]);
  endtask

  task automatic step();
    @(negedge clk);
    j++;
  endtask

  // compare run: idle level 1, exponent n, start s, compare value c, length len
  task automatic cmp_run(input int n, input logic [15:0] s, input logic [15:0] c,
                         input logic [1:0] isel, input int len, input string tag);
    int p;
    logic eo, ei;
    logic [15:0] v;
    p = 1 << n;
    wr(3'd0, 8'h20 | 8'(n));
    wr(3'd1, {6'd0, isel});
    wr16(3'd2, s);
    wr16(3'd4, c);
    check(tmr_out == 1'b1, {tag, " R6 idle level"}, tmr_out, 1);
    wr(3'd0, 8'hA0 | 8'(n));
    j = 0; eo = 1'b1;
    for (int k = 0; k < len; k++) begin
      step();
      ei = ((j % p) == 0) && (16'(s + j / p - 1) == c);
      if (ei) eo = ~eo;
      check(irq == (ei && isel != 2'b01), {tag, " R4/R10 irq"}, irq, ei && isel != 2'b01);
      check(tmr_out == eo, {tag, " R6 toggle"}, tmr_out, eo);
    end
    rd16(3'd2, v);
    check(v == 16'(s + len / p), {tag, " R5 count after run"}, v, 16'(s + len / p));
    wr(3'd0, 8'h00);
  endtask

  initial begin
    logic [7:0]  b;
    logic [15:0] v, mdl;
    logic        ei;
    int          j0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd8(3'(a), b);
      check(b == 8'h00, "R1 register reset", b, 0);
    end
    check(tmr_out == 1'b0, "R1 tmr_out reset", tmr_out, 0);
    check(irq == 1'b0, "R1 irq reset", irq, 0);

    // R2 register map
    wr(3'd0, 8'h2F); rd8(3'd0, b);
    check(b == 8'h27, "R2 control A readback", b, 8'h27);
    wr(3'd1, 8'hFF); rd8(3'd1, b);
    check(b == 8'h03, "R2 control B readback", b, 8'h03);
    wr16(3'd4, 16'hA55A); rd16(3'd4, v);
    check(v == 16'hA55A, "R2 compare readback", v, 16'hA55A);
    wr16(3'd6, 16'h1234); rd16(3'd6, v);
    check(v == 16'h1234, "R2 capture readback", v, 16'h1234);
    wr(3'd1, 8'h00);

    // R3 prescaler sweep over every exponent
    for (int n = 0; n < 8; n++) begin
      wr(3'd0, 8'(n));
      wr16(3'd2, 16'h0000);
      wr16(3'd4, 16'hFFFF);
      wr(3'd0, 8'h80 | 8'(n));
      repeat (300) @(negedge clk);
      rd16(3'd2, v);
      check(v == 16'(300 >> n), "R3 prescaled count", v, 300 >> n);
    end
    // R3 prescaler restarts after disable
    wr(3'd0, 8'h02);
    wr16(3'd2, 16'h0000);
    wr(3'd0, 8'h82);
    repeat (3) @(negedge clk);
    rd16(3'd2, v);
    check(v == 16'd0, "R3 no advance before 2^N", v, 0);
    @(negedge clk);
    rd16(3'd2, v);
    check(v == 16'd1, "R3 first advance at 2^N", v, 1);
    wr(3'd0, 8'h00);

    // R4 R5 R6 R10 compare mode
    cmp_run(0, 16'hFFF0, 16'h0005, 2'b00, 40, "cmpA");
    cmp_run(1, 16'hFFFE, 16'h0000, 2'b11, 20, "cmpB");
    cmp_run(3, 16'h0010, 16'h0012, 2'b10, 40, "cmpC");
    cmp_run(0, 16'h0000, 16'h0003, 2'b01, 10, "cmpD masked");

    // R7 R8 capture, rising polarity, exponent 0 and 2
    for (int n = 0; n < 3; n += 2) begin
      tmr_in = 1'b0;
      wr(3'd0, 8'h50 | 8'(n));
      wr(3'd1, 8'h00);
      wr16(3'd2, 16'h0000);
      wr16(3'd4, 16'hFFFF);
      wr16(3'd6, 16'h0000);
      wr(3'd0, 8'hD0 | 8'(n));
      j = 0;
      for (int t = 0; t < 3; t++) begin
        repeat (7 + 5 * t) step();
        tmr_in = 1'b1; j0 = j;
        step(); check(irq == 1'b0, "R7 no irq at +1", irq, 0);
        step(); check(irq == 1'b0, "R7 no irq at +2", irq, 0);
        step(); check(irq == 1'b1, "R7 irq at +3", irq, 1);
        rd16(3'd6, v);
        check(v == 16'((j0 + 2) >> n), "R7 captured count", v, (j0 + 2) >> n);
        repeat (4) step();
        tmr_in = 1'b0;
        for (int q = 0; q < 6; q++) begin
          step();
          check(irq == 1'b0, "R8 falling edge ignored", irq, 0);
        end
        rd16(3'd6, mdl);
        check(mdl == v, "R8 capture unchanged", mdl, v);
      end
      wr(3'd0, 8'h00);
    end

    // R7 falling polarity with captures only, R10 reload-only masks capture irq
    tmr_in = 1'b1;
    wr(3'd0, 8'h40);
    wr(3'd1, 8'h02);
    wr16(3'd2, 16'h0100);
    wr16(3'd4, 16'hFFFF);
    wr16(3'd6, 16'h0000);
    wr(3'd0, 8'hC0);
    j = 0;
    repeat (9) step();
    tmr_in = 1'b0; j0 = j;
    for (int q = 0; q < 5; q++) begin
      step();
      check(irq == 1'b0, "R10 capture irq masked", irq, 0);
    end
    rd16(3'd6, v);
    check(v == 16'(16'h0100 + j0 + 2), "R7 falling capture value", v, 16'h0100 + j0 + 2);
    wr(3'd0, 8'h00);

    // R9 R10 capture-mode reload
    for (int m = 0; m < 2; m++) begin
      tmr_in = 1'b0;
      wr(3'd0, 8'h50);
      wr(3'd1, (m == 0) ? 8'h00 : 8'h01);
      wr16(3'd2, 16'h0000);
      wr16(3'd4, 16'h0005);
      wr16(3'd6, 16'h0000);
      wr(3'd0, 8'hD0);
      mdl = 16'h0000;
      for (int k = 0; k < 20; k++) begin
        ei = (mdl == 16'h0005);
        mdl = ei ? 16'h0001 : mdl + 16'd1;
        @(negedge clk);
        check(irq == (ei && m == 0), "R9/R10 reload irq", irq, ei && m == 0);
      end
      rd16(3'd2, v);
      check(v == mdl, "R9 count after reloads", v, mdl);
      rd16(3'd6, v);
      check(v == 16'h0000, "R9 capture pair untouched", v, 0);
      wr(3'd0, 8'h00);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule